// File: doc/BRIEF.md
# Reservation-Based In-Order Issue Unit

This block is the issue stage of a pipeline in which several pipelined function units with different fixed latencies finish out of order. Each cycle it is offered one decoded instruction (an opcode class, two source register numbers and one destination register number) on a valid/ready handshake. It checks the data hazards and the structural hazard on the shared register write port. If any hazard is present it holds the instruction with ready low. Otherwise it issues the instruction to the function unit that its class selects.

Instructions leave strictly in program order, and operands are read at issue. A later write to a register that an earlier instruction reads therefore needs no check. A busy bit per register tracks in-flight destinations and covers read-after-write and write-after-write hazards. The function units report each register write on a writeback input, and that clears the busy bit. The write port is tracked by a shift register of future claims. An instruction whose class has latency L needs the port L cycles after it issues. It may issue only if that future slot is free, and issuing claims it. Once a function unit accepts an instruction it never stalls, so all blocking takes place here.

Top module: `resv_issue_unit`

## Requirements
- R1: After reset, no register is busy and no write-port slot is claimed, so the first instruction offered issues in the cycle it is presented.
- R2: `iss_fu` is one-hot and nonzero only in a cycle where both `in_valid` and `in_ready` are high. Class c drives bit c, so class 0 selects unit 0 and class 3 selects unit 3. `iss_dst` carries the destination of the issued instruction.
- R3: Class latencies are: class 0 = 1 cycle, class 1 = 2, class 2 = 4, class 3 = 6. An instruction issued in cycle n claims the write port for cycle n+L and is expected to be written back in that cycle.
- R4: An instruction is held while either of its source registers is the destination of an issued instruction that has not yet been written back.
- R5: An instruction is held while its destination register is still pending from an earlier issued instruction.
- R6: Register 0 is never reserved. A source or destination of 0 never causes a hold, and an instruction writing register 0 still claims the write port.
- R7: An instruction is held while the write-port slot L cycles ahead is already claimed. Each later cycle it looks one slot further on, so it issues as soon as the slot it would use is free. No two writebacks ever fall in the same cycle.
- R8: A writeback in the same cycle as the check releases the register for that check, so the dependent instruction issues in that cycle.
- R9: When an issue sets one register busy in the same cycle that a writeback clears another, both updates take effect.
- R10: While reset is asserted, `in_ready` is low and nothing issues.
- R11: Write-after-read is not checked. An instruction whose destination is a source of an earlier instruction that is still in flight issues without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction has no hazard and is accepted this cycle |
| in_class | input | 2 | Opcode class (selects unit and latency) |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| in_dst | input | 3 | Destination register |
| iss_fu | output | 4 | One-hot issue strobe per function unit |
| iss_dst | output | 3 | Destination register of the instruction being issued |
| wb_valid | input | 1 | A function unit writes a register this cycle |
| wb_reg | input | 3 | Register being written back |

## Verification
A busy bit left set by a lost clear shows up at the ports as `in_ready` staying low for the next reader of that register. Because a writeback never arrives to release it, this becomes a permanent hold. A lost set or a lost port claim shows up within one latency as an early issue, or as two writebacks scheduled for the same cycle. A misplaced shift or offset in the write-port reservation changes the exact number of hold cycles that a crafted mix of latencies produces. For that reason every hold length is compared with a hand-computed value for that cycle.

// File: rtl/resv_issue_pkg.sv
// Package: shared defaults and the opcode-class table of the issue unit.
// Assumes the number of classes equals the number of function units.
package resv_issue_pkg;

    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_CLASS_W  = 2;
    localparam int DEF_NUM_FU   = 4;
    localparam int DEF_RESV_LEN = 8;

    // Latency in cycles of the unit that serves a class; equals the write-port offset.
    function automatic int class_latency(input int cls);
        case (cls)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

    // Index of the function unit serving a class.
    function automatic int class_unit(input int cls);
        return cls;
    endfunction

endpackage

// File: rtl/resv_class_decode.sv
// Module: maps an opcode class to a one-hot unit select and a latency.
// Assumes the class table in resv_issue_pkg; purely combinational.
module resv_class_decode
    import resv_issue_pkg::*;
#(
    parameter int CLASS_W = DEF_CLASS_W,
    parameter int NUM_FU  = DEF_NUM_FU,
    parameter int LAT_W   = 3
) (
    input  logic [CLASS_W-1:0] cls,
    output logic [NUM_FU-1:0]  fu_sel,
    output logic [LAT_W-1:0]   lat
);

    // One select line per unit, asserted when the table names that unit.
    for (genvar f = 0; f < NUM_FU; f++) begin : g_sel
        assign fu_sel[f] = (class_unit(int'(cls)) == f);
    end

    // Latency lookup from the class table.
    always_comb begin
        lat = LAT_W'(class_latency(int'(cls)));
    end

endmodule

// File: rtl/resv_reg_board.sv
// Module: one reservation bit per architectural register.
// Assumes register 0 is never reserved; a clear and a set of the same register
// in one cycle leaves it set. The busy view given out already hides a register
// whose writeback happens this cycle.
module resv_reg_board #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_reg,
    input  logic                clr_en,
    input  logic [REG_W-1:0]    clr_reg,
    output logic [NUM_REGS-1:0] busy_eff
);

    logic [NUM_REGS-1:0] busy_q;
    logic [NUM_REGS-1:0] clr_mask;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign clr_mask[r] = clr_en && (clr_reg == REG_W'(r));
        if (r == 0) begin : g_zero
            assign busy_q[r] = 1'b0;
        end else begin : g_live
            logic bit_q;
            logic set_hit;
            assign set_hit = set_en && (set_reg == REG_W'(r));
            // Track whether register r has a write still in flight.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_hit) begin
                    bit_q <= 1'b1;
                end else if (clr_mask[r]) begin
                    bit_q <= 1'b0;
                end
            end
            assign busy_q[r] = bit_q;
        end
    end

    // Busy as seen by this cycle's check, with this cycle's writeback bypassed.
    assign busy_eff = busy_q & ~clr_mask;

endmodule

// File: rtl/resv_slot_shift.sv
// Module: reservation shift register for one timed shared resource.
// Bit t set means the resource is taken t cycles from now. The register moves
// one place toward bit 0 each clock; a claim at index t is stored before the shift.
module resv_slot_shift #(
    parameter int LEN   = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_en,
    input  logic [IDX_W-1:0] claim_idx,
    output logic [LEN-1:0]   slots
);

    logic [LEN-1:0] claim_mask;

    // Decode the claimed offset into a single-bit mask.
    always_comb begin
        claim_mask = '0;
        if (claim_en) begin
            claim_mask[claim_idx] = 1'b1;
        end
    end

    // Add the new claim, then advance time by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            slots <= (slots | claim_mask) >> 1;
        end
    end

endmodule

// File: rtl/resv_hazard_check.sv
// Module: combines register and write-port reservations into one hold signal.
// Assumes the busy view already excludes register 0 and this cycle's writeback.
module resv_hazard_check #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 3,
    parameter int LEN      = 8,
    parameter int LAT_W    = 3
) (
    input  logic [NUM_REGS-1:0] busy_eff,
    input  logic [REG_W-1:0]    src_a,
    input  logic [REG_W-1:0]    src_b,
    input  logic [REG_W-1:0]    dst,
    input  logic [LEN-1:0]      slots,
    input  logic [LAT_W-1:0]    lat,
    output logic                hold
);

    logic raw_hit;
    logic waw_hit;
    logic port_hit;

    // Read-after-write on either source, write-after-write on the destination.
    always_comb begin
        raw_hit = busy_eff[src_a] || busy_eff[src_b];
        waw_hit = busy_eff[dst];
    end

    // The write port is already taken in the cycle this instruction would write.
    always_comb begin
        port_hit = slots[lat];
    end

    assign hold = raw_hit || waw_hit || port_hit;

endmodule

// File: rtl/resv_issue_unit.sv
// Module: in-order issue controller with register and write-port reservations.
// Assumes units never stall after accepting, exactly one writeback per cycle at
// most (guaranteed by the port reservation), and class latencies of 1..LEN-1.
module resv_issue_unit
    import resv_issue_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int CLASS_W  = DEF_CLASS_W,
    parameter int NUM_FU   = DEF_NUM_FU,
    parameter int RESV_LEN = DEF_RESV_LEN,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int LAT_W   = $clog2(RESV_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CLASS_W-1:0] in_class,
    input  logic [REG_W-1:0]   in_src_a,
    input  logic [REG_W-1:0]   in_src_b,
    input  logic [REG_W-1:0]   in_dst,
    output logic [NUM_FU-1:0]  iss_fu,
    output logic [REG_W-1:0]   iss_dst,
    input  logic               wb_valid,
    input  logic [REG_W-1:0]   wb_reg
);

    logic [NUM_FU-1:0]   fu_sel;
    logic [LAT_W-1:0]    lat;
    logic [NUM_REGS-1:0] busy_eff;
    logic [RESV_LEN-1:0] port_slots;
    logic                hold;
    logic                fire;

    resv_class_decode #(
        .CLASS_W (CLASS_W),
        .NUM_FU  (NUM_FU),
        .LAT_W   (LAT_W)
    ) i_decode (
        .cls    (in_class),
        .fu_sel (fu_sel),
        .lat    (lat)
    );

    resv_reg_board #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) i_board (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (fire),
        .set_reg  (in_dst),
        .clr_en   (wb_valid),
        .clr_reg  (wb_reg),
        .busy_eff (busy_eff)
    );

    resv_slot_shift #(
        .LEN   (RESV_LEN),
        .IDX_W (LAT_W)
    ) i_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (fire),
        .claim_idx (lat),
        .slots     (port_slots)
    );

    resv_hazard_check #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .LEN      (RESV_LEN),
        .LAT_W    (LAT_W)
    ) i_check (
        .busy_eff (busy_eff),
        .src_a    (in_src_a),
        .src_b    (in_src_b),
        .dst      (in_dst),
        .slots    (port_slots),
        .lat      (lat),
        .hold     (hold)
    );

    // Accept only out of reset and with no hazard; issue on a completed handshake.
    always_comb begin
        in_ready = rst_n && !hold;
        fire     = in_valid && in_ready;
        iss_fu   = fire ? fu_sel : '0;
        iss_dst  = in_dst;
    end

endmodule

// File: rtl/resv_issue_checker.sv
// Module: port-level properties of the issue unit, bound to every instance.
module resv_issue_checker #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [REG_W-1:0]  in_src_a,
    input logic [REG_W-1:0]  in_dst,
    input logic [NUM_FU-1:0] iss_fu,
    input logic [REG_W-1:0]  iss_dst,
    input logic              wb_valid,
    input logic [REG_W-1:0]  wb_reg
);

    AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(iss_fu)); // R2

    AST_ISSUE_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) (iss_fu != '0) |-> (in_valid && in_ready)); // R2

    AST_RAW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_fu != '0) && $past(iss_fu != '0) && ($past(iss_dst) != '0) && (in_src_a == $past(iss_dst)))
        |-> (wb_valid && (wb_reg == in_src_a))); // R4

    AST_WAW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_fu != '0) && $past(iss_fu != '0) && ($past(iss_dst) != '0) && (in_dst == $past(iss_dst)))
        |-> (wb_valid && (wb_reg == in_dst))); // R5

    // Ready stays low throughout reset.
    always @(posedge clk) begin
        if (rst_n == 1'b0) begin
            AST_RESET_NOT_READY: assert (!in_ready); // R10
        end
    end

endmodule

bind resv_issue_unit resv_issue_checker #(
    .NUM_FU (NUM_FU),
    .REG_W  (REG_W)
) i_resv_issue_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_src_a (in_src_a),
    .in_dst   (in_dst),
    .iss_fu   (iss_fu),
    .iss_dst  (iss_dst),
    .wb_valid (wb_valid),
    .wb_reg   (wb_reg)
);

// File: tb/test_resv_issue_unit.sv
// Bench: driver task queues expected issues, a monitor pops and compares them,
// and a function-unit model returns writebacks at issue cycle + class latency.
module test_resv_issue_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_class = '0;
    logic [2:0] in_src_a = '0;
    logic [2:0] in_src_b = '0;
    logic [2:0] in_dst = '0;
    logic [3:0] iss_fu;
    logic [2:0] iss_dst;
    logic       wb_valid = 1'b0;
    logic [2:0] wb_reg = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int exp_fu_q[$];
    int exp_dst_q[$];
    int wb_sched[int];

    resv_issue_unit i_resv_issue_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_class (in_class),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .in_dst   (in_dst),
        .iss_fu   (iss_fu),
        .iss_dst  (iss_dst),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Latency per class as stated in R3.
    function automatic int lat_of(input int cls);
        case (cls)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Function-unit model: drive the writeback scheduled for the current cycle.
    always @(posedge clk) begin
        #1;
        if (wb_sched.exists(cyc)) begin
            wb_valid = 1'b1;
            wb_reg   = 3'(wb_sched[cyc]);
            wb_sched.delete(cyc);
        end else begin
            wb_valid = 1'b0;
        end
    end

    // Monitor: compare each issue with the queued expectation and schedule its writeback.
    always @(negedge clk) begin
        if (rst_n && iss_fu != '0) begin
            if (exp_fu_q.size() == 0) begin
                check(1'b0, "R2 unexpected issue", int'(iss_fu), 0);
            end else begin
                automatic int efu = exp_fu_q.pop_front();
                automatic int edst = exp_dst_q.pop_front();
                check(iss_fu == 4'(1 << efu), "R2 unit select", int'(iss_fu), 1 << efu);
                check(int'(iss_dst) == edst, "R2 issued destination", int'(iss_dst), edst);
                check(!wb_sched.exists(cyc + lat_of(efu)), "R7 single writeback per cycle",
                      1, 0);
                wb_sched[cyc + lat_of(efu)] = edst;
            end
        end
        if (rst_n && !in_valid) begin
            check(iss_fu == '0, "R2 no issue without valid", int'(iss_fu), 0);
        end
    end

    // Driver: offer one instruction and check how many cycles it is held.
    task automatic send(input int cls, input int a, input int b, input int d,
                        input int exp_wait, input string req);
        int w;
        exp_fu_q.push_back(cls);
        exp_dst_q.push_back(d);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_class = 2'(cls);
        in_src_a = 3'(a);
        in_src_b = 3'(b);
        in_dst   = 3'(d);
        w = 0;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            w++;
            if (w > 40) break;
        end
        check(w == exp_wait, req, w, exp_wait);
    endtask

    task automatic idle(input int n);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        // R10: valid offered during reset must not be accepted.
        in_valid = 1'b1;
        in_dst   = 3'd1;
        repeat (3) begin
            @(negedge clk);
            check(!in_ready, "R10 ready low in reset", int'(in_ready), 0);
            check(iss_fu == '0, "R10 no issue in reset", int'(iss_fu), 0);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R1: first instruction after reset issues at once.
        send(0, 1, 2, 3, 0, "R1 first issue");
        idle(10);

        // R4 and R3: reader of a latency-6 result waits until its writeback.
        send(3, 1, 2, 5, 0, "R3 class 3 issue");
        send(0, 5, 0, 6, 5, "R4 held on source until writeback");
        idle(10);

        // R4 on the second source.
        send(1, 0, 0, 4, 0, "R3 class 1 issue");
        send(0, 0, 4, 7, 1, "R4 second source held");
        idle(10);

        // R5: same destination waits for the earlier latency-4 write.
        send(2, 0, 0, 2, 0, "R3 class 2 issue");
        send(0, 0, 0, 2, 3, "R5 destination held");
        idle(10);

        // R7: latency-1 after latency-2 collides on the port once.
        send(1, 0, 0, 1, 0, "R7 first claim");
        send(0, 0, 0, 2, 1, "R7 held one cycle on port");
        idle(10);

        // R7: mixed latencies, class 1 has to slide past two claimed slots.
        send(3, 0, 0, 1, 0, "R7 claim at +6");
        send(2, 0, 0, 2, 0, "R7 claim at +4 free");
        send(0, 0, 0, 3, 0, "R7 claim at +1 free");
        send(1, 0, 0, 4, 2, "R7 sliding claim");
        idle(10);

        // R6: register 0 never reserved, but still uses the port.
        send(3, 1, 2, 0, 0, "R6 write to r0");
        send(0, 0, 0, 0, 0, "R6 r0 never busy");
        idle(10);

        // R11: writing a source of an in-flight instruction is not held.
        send(3, 3, 0, 5, 0, "R11 reader in flight");
        send(0, 0, 0, 3, 0, "R11 no WAR hold");
        idle(10);

        // R8 and R9: back-to-back latency-1 chain with same-cycle set and clear.
        send(0, 0, 0, 1, 0, "R9 set r1");
        send(0, 0, 0, 2, 0, "R9 set r2 while r1 clears");
        send(0, 1, 2, 3, 0, "R8 r2 released by same-cycle writeback");
        send(0, 2, 1, 1, 0, "R9 both updates kept");
        idle(12);

        check(exp_fu_q.size() == 0, "R2 all expected issues seen", exp_fu_q.size(), 0);
        check(wb_sched.num() == 0, "R3 all writebacks returned", wb_sched.num(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R1 watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule